// File: doc/BRIEF.md
# Two-Channel Address Break Controller

A debug-assist block with two break channels, A and B. Each channel holds a break address and a control word. Every processor access reported on the access port is compared against that address. When the address is equal, the channel is enabled and the access kind is one the channel accepts, the channel sets a sticky match flag. Both flags drive one shared interrupt request. Software reads the status register to learn which channel fired. It then clears the flag with a read-then-write-zero sequence.

Three qualification rules apply. A fetch marked as discarded never matches, because the prefetch that follows a control-transfer instruction is not executed. A match made while another bus master owns the bus is parked in a one-deep pending bit. That bit becomes a flag on the first cycle after the bus returns to the processor. A pulse on the mask-set input blocks the interrupt request for a short window, so the next instruction always executes before any break is taken. While the module-stop input is high, the block compares nothing, ignores register writes and drops pending breaks.

Top module: `addr_break_ctrl`

## Requirements
- R1: While mstop_i is 1, register writes are ignored, no access can set a flag, and any pending break is discarded.
- R2: After reset, every register reads 0, both channels are disabled and irq_o is 0.
- R3: Register map by reg_addr_i: 0 = break address A, 1 = break address B, 2 = control A, 3 = control B, 4 = status. In a control word, bit 0 is the enable and bits 2:1 select the access kind: 00 fetch, 01 read, 10 write, 11 read or write. The access kind on acc_kind_i is 00 fetch, 01 read, 10 write. An access that matches a channel with the bus held by the processor sets that channel's status bit (bit 0 = A, bit 1 = B) at the next clock edge.
- R4: irq_o is 1 while any status bit is 1 and no mask window is active. A flag stays set until software clears it.
- R5: A status bit clears only when a 0 is written to it after the status register was read while that bit was 1. A write of 0 without such a read, or a write of 1, leaves the bit unchanged.
- R6: A fetch with fetch_discard_i = 1 never sets a flag.
- R7: A match made while dma_owner_i is 1 sets no flag. It is held pending, one per channel, and the flag is set at the first clock edge where dma_owner_i is 0.
- R8: After a clock edge that samples mask_set_i = 1, irq_o is 0 for HOLD (default 3) cycles.
- R9: A channel whose enable bit is 0, or whose access-kind select does not accept the access, does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mstop_i | input | 1 | Module stop: halts matching and blocks writes |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Register read data for reg_addr_i |
| acc_valid_i | input | 1 | Processor access valid |
| acc_kind_i | input | 2 | Access kind: fetch, read, write |
| acc_addr_i | input | AW | Access address |
| fetch_discard_i | input | 1 | This fetch follows a control transfer and is not executed |
| dma_owner_i | input | 1 | Another bus master holds the bus |
| mask_set_i | input | 1 | An instruction that sets the interrupt mask has ended |
| irq_o | output | 1 | Shared break interrupt request |

## Verification
The hardest cases to reach are the deferred break and the stop that cancels it. The bench raises dma_owner_i, issues a matching access, and holds the bus away for several cycles while it checks that the status stays 0. It then releases the bus and expects the flag exactly one edge later. In a second run it asserts mstop_i while the break is parked, releases the bus under stop, and checks that the break is gone. A behavioural model follows the read-arm and write-zero sequence and the mask window cycle by cycle, and irq_o is compared against it on every clock.

// File: rtl/abrk_pkg.sv
package abrk_pkg;
  localparam int unsigned NCH = 2;

  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_READ  = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;

  localparam logic [2:0] RA_BAR  = 3'd0;  // + channel
  localparam logic [2:0] RA_CTL  = 3'd2;  // + channel
  localparam logic [2:0] RA_STAT = 3'd4;

  typedef enum logic [1:0] {
    SEL_FETCH = 2'b00,
    SEL_READ  = 2'b01,
    SEL_WRITE = 2'b10,
    SEL_RW    = 2'b11
  } sel_e;

  typedef struct packed {
    sel_e sel;
    logic en;
  } ctl_t;
endpackage

// File: rtl/abrk_chan.sv
module abrk_chan
  import abrk_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mstop_i,
  input  logic          wr_bar_i,
  input  logic          wr_ctl_i,
  input  logic          wr_clr_i,
  input  logic          rd_stat_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          acc_valid_i,
  input  logic [1:0]    acc_kind_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          discard_i,
  input  logic          dma_i,
  output logic [AW-1:0] bar_o,
  output ctl_t          ctl_o,
  output logic          flag_o
);
  logic [AW-1:0] bar_q;
  ctl_t          ctl_q;
  logic          flag_q, seen_q, pend_q;
  logic          kind_ok, hit, set, clr;

  always_comb begin
    unique case (ctl_q.sel)
      SEL_FETCH: kind_ok = (acc_kind_i == K_FETCH);
      SEL_READ:  kind_ok = (acc_kind_i == K_READ);
      SEL_WRITE: kind_ok = (acc_kind_i == K_WRITE);
      default:   kind_ok = (acc_kind_i == K_READ) || (acc_kind_i == K_WRITE);
    endcase
  end

  assign hit = acc_valid_i && ctl_q.en && !mstop_i && kind_ok && (acc_addr_i == bar_q)
            && !((acc_kind_i == K_FETCH) && discard_i);
  assign set = !mstop_i && !dma_i && (hit || pend_q);
  assign clr = wr_clr_i && seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q  <= '0;
      ctl_q  <= '0;
      flag_q <= 1'b0;
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_bar_i) bar_q <= wdata_i;
      if (wr_ctl_i) ctl_q <= ctl_t'(wdata_i[2:0]);
      // one-deep deferral while another master owns the bus
      if (mstop_i)    pend_q <= 1'b0;
      else if (dma_i) pend_q <= pend_q || hit;
      else            pend_q <= 1'b0;
      if (set)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (clr)                       seen_q <= 1'b0;
      else if (rd_stat_i && flag_q)  seen_q <= 1'b1;
    end
  end

  assign bar_o  = bar_q;
  assign ctl_o  = ctl_q;
  assign flag_o = flag_q;

  p_clear_needs_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(wr_clr_i && seen_q));
  p_stop_drops_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstop_i |=> !pend_q && !$rose(flag_q));
  p_pend_from_dma_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(dma_i));
  p_disabled_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.en && !pend_q |=> !$rose(flag_q));
  p_discard_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_kind_i == K_FETCH && discard_i && !pend_q |=> !$rose(flag_q));
endmodule

// File: rtl/abrk_holdoff.sv
module abrk_holdoff #(
  parameter int unsigned HOLD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mask_set_i,
  output logic block_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (mask_set_i)    cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign block_o = (cnt_q != '0);

  p_window_opens_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_i |=> block_o);
endmodule

// File: rtl/addr_break_ctrl.sv
module addr_break_ctrl
  import abrk_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned HOLD = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mstop_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          acc_valid_i,
  input  logic [1:0]    acc_kind_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          fetch_discard_i,
  input  logic          dma_owner_i,
  input  logic          mask_set_i,
  output logic          irq_o
);
  logic [AW-1:0] bar   [NCH];
  ctl_t          ctl   [NCH];
  logic [NCH-1:0] flags;
  logic          wr_ok, block;

  assign wr_ok = reg_we_i && !mstop_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    abrk_chan #(.AW(AW)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mstop_i    (mstop_i),
      .wr_bar_i   (wr_ok && reg_addr_i == RA_BAR + 3'(i)),
      .wr_ctl_i   (wr_ok && reg_addr_i == RA_CTL + 3'(i)),
      .wr_clr_i   (wr_ok && reg_addr_i == RA_STAT && !reg_wdata_i[i]),
      .rd_stat_i  (reg_re_i && reg_addr_i == RA_STAT),
      .wdata_i    (reg_wdata_i),
      .acc_valid_i(acc_valid_i),
      .acc_kind_i (acc_kind_i),
      .acc_addr_i (acc_addr_i),
      .discard_i  (fetch_discard_i),
      .dma_i      (dma_owner_i),
      .bar_o      (bar[i]),
      .ctl_o      (ctl[i]),
      .flag_o     (flags[i])
    );
  end

  abrk_holdoff #(.HOLD(HOLD)) i_holdoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_set_i(mask_set_i),
    .block_o   (block)
  );

  always_comb begin
    unique case (reg_addr_i)
      3'd0:    reg_rdata_o = bar[0];
      3'd1:    reg_rdata_o = bar[1];
      3'd2:    reg_rdata_o = {{(AW-3){1'b0}}, ctl[0]};
      3'd3:    reg_rdata_o = {{(AW-3){1'b0}}, ctl[1]};
      3'd4:    reg_rdata_o = {{(AW-NCH){1'b0}}, flags};
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = (|flags) && !block;

  p_irq_has_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |flags);
  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mask_set_i) |-> !irq_o);
endmodule

// File: tb/test_addr_break_ctrl.sv
`timescale 1ns/1ps
module test_addr_break_ctrl;
  localparam int AW = 16;
  localparam int HOLD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mstop, we, re, acc_valid, discard, dma, mask_set;
  logic [2:0] addr;
  logic [AW-1:0] wdata, acc_addr;
  logic [1:0] kind;
  logic [AW-1:0] rdata;
  logic irq;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  addr_break_ctrl #(.AW(AW), .HOLD(HOLD)) i_addr_break_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mstop_i(mstop), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .acc_valid_i(acc_valid), .acc_kind_i(kind), .acc_addr_i(acc_addr),
    .fetch_discard_i(discard), .dma_owner_i(dma), .mask_set_i(mask_set), .irq_o(irq)
  );

  // behavioural reference model
  int m_bar[2], m_en[2], m_sel[2], m_flag[2], m_seen[2], m_pend[2];
  int m_hold;

  function automatic bit kind_fits(int sel, logic [1:0] k);
    if (sel == 0) return k == 2'b00;
    if (sel == 1) return k == 2'b01;
    if (sel == 2) return k == 2'b10;
    return k == 2'b01 || k == 2'b10;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_bar[c] = 0; m_en[c] = 0; m_sel[c] = 0;
        m_flag[c] = 0; m_seen[c] = 0; m_pend[c] = 0;
      end
      m_hold = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit h, clr;
        int old_flag;
        old_flag = m_flag[c];
        h = acc_valid && !mstop && m_en[c] != 0 && int'(acc_addr) == m_bar[c]
            && kind_fits(m_sel[c], kind) && !(kind == 2'b00 && discard);
        clr = we && !mstop && addr == 3'd4 && !wdata[c] && m_seen[c] != 0;
        if (!mstop && !dma && (h || m_pend[c] != 0)) m_flag[c] = 1;
        else if (clr) m_flag[c] = 0;
        if (clr) m_seen[c] = 0;
        else if (re && addr == 3'd4 && old_flag != 0) m_seen[c] = 1;
        if (mstop) m_pend[c] = 0;
        else if (dma) m_pend[c] = (m_pend[c] != 0 || h) ? 1 : 0;
        else m_pend[c] = 0;
        if (we && !mstop && int'(addr) == c) m_bar[c] = int'(wdata);
        if (we && !mstop && int'(addr) == c + 2) begin
          m_en[c] = int'(wdata[0]);
          m_sel[c] = int'(wdata[2:1]);
        end
      end
      if (mask_set) m_hold = HOLD;
      else if (m_hold > 0) m_hold = m_hold - 1;
    end
  end

  function automatic logic m_irq();
    return (m_flag[0] != 0 || m_flag[1] != 0) && m_hold == 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of the interrupt request (R4, R8)
  always @(negedge clk) if (rst_n) check(irq === m_irq(), "R4", int'(irq), int'(m_irq()));

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [2:0] a, logic [AW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, int exp, string req);
    re = 1'b1; addr = a;
    #1 check(int'(rdata) == exp, req, int'(rdata), exp);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic rd_stat(string req);
    rd(3'd4, m_flag[1] * 2 + m_flag[0], req);
  endtask

  task automatic access(logic [1:0] k, logic [AW-1:0] a, logic disc);
    acc_valid = 1'b1; kind = k; acc_addr = a; discard = disc;
    @(negedge clk);
    acc_valid = 1'b0; discard = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 8);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    mstop = 1'b1; we = 0; re = 0; acc_valid = 0; discard = 0; dma = 0; mask_set = 0;
    addr = '0; wdata = '0; acc_addr = '0; kind = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R2: reset state
    rd(3'd0, 0, "R2"); rd(3'd2, 0, "R2"); rd(3'd4, 0, "R2");
    check(irq == 1'b0, "R2", int'(irq), 0);
    // R1: writes blocked under module stop
    wreg(3'd0, 16'h1234);
    rd(3'd0, 0, "R1");
    mstop = 1'b0;
    wreg(3'd0, 16'h1234); wreg(3'd2, 16'h0001);
    wreg(3'd1, 16'h0400); wreg(3'd3, 16'h0005);
    rd(3'd0, 'h1234, "R3"); rd(3'd3, 5, "R3");
    // R6: discarded fetch
    access(2'b00, 16'h1234, 1'b1); idle(1);
    rd(3'd4, 0, "R6");
    // R9: kind mismatch
    access(2'b01, 16'h1234, 1'b0); idle(1);
    rd(3'd4, 0, "R9");
    // R3/R4: fetch match on A
    access(2'b00, 16'h1234, 1'b0);
    check(irq == 1'b1, "R4", int'(irq), 1);
    // R5: write 0 without prior read
    wreg(3'd4, 16'h0000);
    check(irq == 1'b1, "R5", int'(irq), 1);
    rd(3'd4, 1, "R3");
    wreg(3'd4, 16'h0003);
    rd(3'd4, 1, "R5");
    wreg(3'd4, 16'h0000);
    check(irq == 1'b0, "R5", int'(irq), 0);
    rd(3'd4, 0, "R5");
    // channel B: write only
    access(2'b01, 16'h0400, 1'b0);
    rd(3'd4, 0, "R9");
    access(2'b10, 16'h0400, 1'b0);
    rd(3'd4, 2, "R3");
    access(2'b00, 16'h1234, 1'b0);
    rd(3'd4, 3, "R4");
    wreg(3'd4, 16'h0002);
    check(irq == 1'b1, "R4", int'(irq), 1);
    rd(3'd4, 2, "R5");
    wreg(3'd4, 16'h0000);
    rd(3'd4, 0, "R5");
    // R7: deferral while another master owns the bus
    dma = 1'b1;
    access(2'b00, 16'h1234, 1'b0);
    idle(3);
    rd(3'd4, 0, "R7");
    dma = 1'b0;
    idle(1);
    rd(3'd4, 1, "R7");
    wreg(3'd4, 16'h0000);
    rd_stat("R7");
    // R8: mask window
    access(2'b00, 16'h1234, 1'b0);
    mask_set = 1'b1; @(negedge clk); mask_set = 1'b0;
    check(irq == 1'b0, "R8", int'(irq), 0);
    idle(2);
    check(irq == 1'b0, "R8", int'(irq), 0);
    idle(1);
    check(irq == 1'b1, "R8", int'(irq), 1);
    rd(3'd4, 1, "R8");
    wreg(3'd4, 16'h0000);
    // R9: disabled channel
    wreg(3'd2, 16'h0000);
    access(2'b00, 16'h1234, 1'b0); idle(1);
    rd(3'd4, 0, "R9");
    // R3: read-or-write select
    wreg(3'd2, 16'h0007);
    access(2'b01, 16'h1234, 1'b0);
    rd(3'd4, 1, "R3");
    wreg(3'd4, 16'h0000);
    access(2'b10, 16'h1234, 1'b0);
    rd(3'd4, 1, "R3");
    wreg(3'd4, 16'h0000);
    access(2'b00, 16'h1234, 1'b0); idle(1);
    rd(3'd4, 0, "R9");
    // R1: stop discards a pending break
    dma = 1'b1;
    access(2'b10, 16'h1234, 1'b0);
    mstop = 1'b1; idle(1);
    dma = 1'b0; idle(2);
    mstop = 1'b0; idle(1);
    rd(3'd4, 0, "R1");
    // R1: no match under stop
    mstop = 1'b1;
    access(2'b10, 16'h1234, 1'b0);
    mstop = 1'b0; idle(1);
    rd(3'd4, 0, "R1");
    idle(4);
    summary();
  end
endmodule